// File: doc/BRIEF.md
# Ancillary Packet Inserter

This block places one ancillary data packet, prepared ahead of time by a host, into a stream of 10-bit video samples. The host loads every word of the packet through a small register write port: three flag words, the two identifier words, the data count, up to `MAX_UDW` user words and a checksum word. The stored checksum is never transmitted. The block sums the packet words again while it sends them and emits its own checksum in their place.

Video samples arrive on a valid/ready input and leave on a valid/ready output through a single register stage. The input is ready whenever the output register is empty or is being drained (`in_ready = !out_valid || out_ready`). A word held on the output with `out_ready` low stays stable until it is taken. The source marks the first sample of a horizontal blanking gap with `win_start` and gives the gap length on `win_len`. If the packet is armed, enabled and fits in the gap, the packet words replace the blanking samples one for one, starting with the marked sample. Because the replacement is one for one, the sample count and the output pacing never change. `busy` is high while the rest of a packet is still to be sent.

Top module: `anc_pkt_inserter`

## Requirements
- R1: Any accepted input word that is not replaced by a packet word leaves the output register unchanged. It appears on `out_data` with `out_valid` high after the clock edge that accepted it, and words keep their order.
- R2: Register map on `reg_addr`:
  - 0 is control: bit 0 is the insertion enable and bit 1 is the arm bit. Writing a 1 to bit 1 arms the packet.
  - 1 to 3 hold the three flag words.
  - 4 holds the data ID and 5 holds the secondary ID.
  - 6 holds the data count word. Its bits 7:0 give N, the number of user words.
  - 7 is the checksum slot.
  - 8 to 8+MAX_UDW-1 hold the user words.
  - Everything resets to 0.
- R3: An inserted packet is N+7 consecutive output words in this order: the three flag words, data ID, secondary ID, data count word, the N user words, checksum. It replaces the accepted input words that start with the one carrying `win_start`.
- R4: The checksum word has bits 8:0 equal to the sum, modulo 512, of bits 8:0 of the data ID, the secondary ID, the data count and the N user words. Its bit 9 is the inverse of bit 8. The value written to address 7 is never sent.
- R5: A packet is inserted at most once per arming. The arm is used up at the first accepted `win_start` word while idle, whether or not insertion happens there.
- R6: Insertion happens only if N <= MAX_UDW and N+7 <= `win_len`.
- R7: Insertion also needs the control enable bit, `ins_en` and `smpte_mode` all high on the `win_start` word. If any of them is low, the line passes through unchanged.
- R8: `busy` is high from the edge after the first packet word is accepted until the edge that accepts the last packet word. Register writes are ignored while `busy` is high and in the cycle an insertion starts.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smpte_mode | input | 1 | Video processing mode active |
| ins_en | input | 1 | Insertion enable pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 10 | Register write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 10 | Input video word |
| win_start | input | 1 | Input word is the first blanking sample of a window |
| win_len | input | LEN_W | Window length in words, qualified by win_start |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 10 | Output video word |
| busy | output | 1 | Packet insertion in progress |

## Verification
The bench covers three window cases:
- An exact fit (N+7 equal to the window). A length compare that is off by one would drop this packet.
- A window one word too short. The same off-by-one error would write past the gap.
- A data count above `MAX_UDW`.

It checks the arm in two ways. A window that arrives while insertion is disabled must use up the arm. A second window must not receive a repeat packet; a design that kept the arm would insert there. Writes to a user word and to the arm bit are issued in the middle of a packet. A design that did not block them would corrupt the packet on the spot or insert again on the next line. The checksum is checked with data count bits 8 and 9 set, so a design that summed the wrong bits, or sent the stored slot, would show a wrong final word.

// File: rtl/anc_ins_pkg.sv
`timescale 1ns/1ps
package anc_ins_pkg;
  typedef logic [9:0] word_t;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_ADF0 = 1;
  localparam int A_DID  = 4;
  localparam int A_SDID = 5;
  localparam int A_DC   = 6;
  localparam int A_CSUM = 7;
  localparam int A_UDW0 = 8;

  localparam int FLAG_WORDS = 3;
  localparam int OVERHEAD   = 7;  // flags + ids + count + checksum
  localparam int FIRST_UDW  = 6;  // packet index of first user word

  function automatic word_t csum_word(input logic [8:0] s);
    return {~s[8], s};
  endfunction
endpackage

// File: rtl/anc_ins_regs.sv
`timescale 1ns/1ps
module anc_ins_regs
  import anc_ins_pkg::*;
#(
  parameter int MAX_UDW = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  word_t                     wdata,
  input  logic                      block,
  input  logic                      arm_clear,
  output logic                      en_bit,
  output logic                      armed,
  output logic [FLAG_WORDS-1:0][9:0] adf,
  output word_t                     did,
  output word_t                     sdid,
  output word_t                     dc,
  output logic [MAX_UDW-1:0][9:0]   udw
);
  logic wr_ok;
  assign wr_ok = we && !block;

  // control, identifiers and count; the checksum slot is accepted and dropped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_bit <= 1'b0;
      armed  <= 1'b0;
      did    <= '0;
      sdid   <= '0;
      dc     <= '0;
    end else begin
      if (arm_clear) armed <= 1'b0;
      if (wr_ok) begin
        if (addr == ADDR_W'(A_CTRL)) begin
          en_bit <= wdata[0];
          if (wdata[1]) armed <= 1'b1;
        end
        if (addr == ADDR_W'(A_DID))  did  <= wdata;
        if (addr == ADDR_W'(A_SDID)) sdid <= wdata;
        if (addr == ADDR_W'(A_DC))   dc   <= wdata;
      end
    end
  end

  for (genvar g = 0; g < FLAG_WORDS; g++) begin : g_adf
    always_ff @(posedge clk) begin
      if (!rst_n)                                      adf[g] <= '0;
      else if (wr_ok && addr == ADDR_W'(A_ADF0 + g))   adf[g] <= wdata;
    end
  end

  for (genvar g = 0; g < MAX_UDW; g++) begin : g_udw
    always_ff @(posedge clk) begin
      if (!rst_n)                                      udw[g] <= '0;
      else if (wr_ok && addr == ADDR_W'(A_UDW0 + g))   udw[g] <= wdata;
    end
  end
endmodule

// File: rtl/anc_ins_seq.sv
`timescale 1ns/1ps
module anc_ins_seq
  import anc_ins_pkg::*;
#(
  parameter int MAX_UDW = 16,
  parameter int LEN_W   = 8,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             win_start,
  input  logic [LEN_W-1:0] win_len,
  input  logic             armed,
  input  logic             en_ok,
  input  logic [7:0]       n_udw,
  output logic             busy,
  output logic             start,
  output logic             ins_now,
  output logic             is_last,
  output logic             arm_clear,
  output logic [IDX_W-1:0] idx_now
);
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic [15:0]      need, last_idx;
  logic             fits, window;

  assign need     = 16'(n_udw) + 16'(OVERHEAD);
  assign last_idx = 16'(n_udw) + 16'(OVERHEAD - 1);
  assign fits     = (16'(n_udw) <= 16'(MAX_UDW)) && (need <= 16'(win_len));

  assign window    = accept && win_start && !busy_q;
  assign arm_clear = window && armed;
  assign start     = arm_clear && en_ok && fits;
  assign ins_now   = (accept && busy_q) || start;
  assign idx_now   = busy_q ? idx_q : '0;
  assign is_last   = (16'(idx_now) == last_idx);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (ins_now) begin
      busy_q <= !is_last;
      idx_q  <= idx_now + IDX_W'(1);
    end
  end
endmodule

// File: rtl/anc_ins_csum.sv
`timescale 1ns/1ps
module anc_ins_csum
  import anc_ins_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] idx_now,
  input  logic [7:0]       n_udw,
  input  logic [8:0]       word_lo,
  output logic [8:0]       sum
);
  logic in_range;
  // packet indices 3 (data ID) through 5+N (last user word) are summed
  assign in_range = (16'(idx_now) >= 16'(FLAG_WORDS)) &&
                    (16'(idx_now) <= 16'(n_udw) + 16'(FIRST_UDW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 sum <= '0;
    else if (step) begin
      if (idx_now == '0)        sum <= '0;
      else if (in_range)        sum <= sum + word_lo;
    end
  end
endmodule

// File: rtl/anc_pkt_inserter.sv
`timescale 1ns/1ps
module anc_pkt_inserter
  import anc_ins_pkg::*;
#(
  parameter int MAX_UDW = 16,
  parameter int LEN_W   = 8,
  parameter int ADDR_W  = $clog2(A_UDW0 + MAX_UDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smpte_mode,
  input  logic              ins_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [9:0]        reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [9:0]        in_data,
  input  logic              win_start,
  input  logic [LEN_W-1:0]  win_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [9:0]        out_data,
  output logic              busy
);
  localparam int IDX_W = $clog2(MAX_UDW + OVERHEAD);
  localparam int UW    = $clog2(MAX_UDW);

  logic                      en_bit, armed, arm_clear;
  logic [FLAG_WORDS-1:0][9:0] adf;
  word_t                     did, sdid, dc, pkt_word;
  logic [MAX_UDW-1:0][9:0]   udw;
  logic                      accept, en_ok, start_w, ins_now, is_last;
  logic [IDX_W-1:0]          idx_now, u_idx;
  logic [8:0]                sum;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign en_ok    = en_bit && ins_en && smpte_mode;

  anc_ins_regs #(.MAX_UDW(MAX_UDW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .block(busy || start_w), .arm_clear(arm_clear), .en_bit(en_bit), .armed(armed),
    .adf(adf), .did(did), .sdid(sdid), .dc(dc), .udw(udw)
  );

  anc_ins_seq #(.MAX_UDW(MAX_UDW), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .win_start(win_start),
    .win_len(win_len), .armed(armed), .en_ok(en_ok), .n_udw(dc[7:0]),
    .busy(busy), .start(start_w), .ins_now(ins_now), .is_last(is_last),
    .arm_clear(arm_clear), .idx_now(idx_now)
  );

  anc_ins_csum #(.IDX_W(IDX_W)) u_csum (
    .clk(clk), .rst_n(rst_n), .step(ins_now), .idx_now(idx_now),
    .n_udw(dc[7:0]), .word_lo(pkt_word[8:0]), .sum(sum)
  );

  assign u_idx = idx_now - IDX_W'(FIRST_UDW);

  always_comb begin
    pkt_word = '0;
    if (idx_now == IDX_W'(0))      pkt_word = adf[0];
    else if (idx_now == IDX_W'(1)) pkt_word = adf[1];
    else if (idx_now == IDX_W'(2)) pkt_word = adf[2];
    else if (idx_now == IDX_W'(3)) pkt_word = did;
    else if (idx_now == IDX_W'(4)) pkt_word = sdid;
    else if (idx_now == IDX_W'(5)) pkt_word = dc;
    else if (is_last)              pkt_word = csum_word(sum);
    else if (u_idx < IDX_W'(MAX_UDW)) pkt_word = udw[u_idx[UW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_data <= ins_now ? pkt_word : in_data;
    end
  end
endmodule

// File: rtl/anc_pkt_inserter_chk.sv
`timescale 1ns/1ps
module anc_pkt_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [9:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [9:0] out_data,
  input logic       busy,
  input logic       start_w,
  input logic       ins_now,
  input logic       is_last
);
  // R1: untouched words appear one edge later
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !ins_now) |=> (out_valid && out_data == $past(in_data)));

  // R9: output held under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: checksum bit 9 is the inverse of bit 8
  a_r4_csum_b9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_now && is_last) |=> (out_data[9] == !out_data[8]));

  // R8: busy only rises after a packet start
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_w));

  // R5: no new start while a packet is running
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_w);
endmodule

bind anc_pkt_inserter anc_pkt_inserter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .busy(busy), .start_w(start_w), .ins_now(ins_now),
  .is_last(is_last)
);

// File: tb/anc_pkt_inserter_tb.sv
`timescale 1ns/1ps
module anc_pkt_inserter_tb;
  localparam int MAXU = 16;
  localparam int AW   = 5;
  localparam int LW   = 8;
  localparam int LINE = 40;
  localparam int WP   = 5;
  localparam int NV   = 9;
  // fields: n, win_len, en_bit, ins_en, smpte, backpressure, expect_insert
  localparam int VEC [NV][7] = '{
    '{ 4, 20, 1, 1, 1, 0, 1},   // R3 R4 normal
    '{ 0,  7, 1, 1, 1, 0, 1},   // R6 exact fit, no user words
    '{ 5, 11, 1, 1, 1, 0, 0},   // R6 one short
    '{16, 23, 1, 1, 1, 1, 1},   // R6 max count, R9 back-pressure
    '{ 3, 20, 0, 1, 1, 0, 0},   // R7 enable bit low
    '{ 3, 20, 1, 0, 1, 0, 0},   // R7 pin low
    '{ 3, 20, 1, 1, 0, 0, 0},   // R7 mode low
    '{17, 30, 1, 1, 1, 0, 0},   // R6 count above max
    '{ 2, 10, 1, 1, 1, 1, 1}    // R3 R9
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, smpte_mode, ins_en, reg_we, in_valid, in_ready, win_start;
  logic out_valid, out_ready, busy;
  logic [AW-1:0] reg_addr;
  logic [9:0] reg_wdata, in_data, out_data;
  logic [LW-1:0] win_len;

  anc_pkt_inserter #(.MAX_UDW(MAXU), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smpte_mode(smpte_mode), .ins_en(ins_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .win_start(win_start), .win_len(win_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  logic [9:0] m_adf [3];
  logic [9:0] m_did, m_sdid, m_dc;
  logic [9:0] m_udw [MAXU];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input bit upd);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 10'(d);
    @(negedge clk);
    reg_we = 1'b0;
    if (upd) begin
      if (a >= 1 && a <= 3) m_adf[a-1] = 10'(d);
      if (a == 4) m_did = 10'(d);
      if (a == 5) m_sdid = 10'(d);
      if (a == 6) m_dc = 10'(d);
      if (a >= 8 && a < 8 + MAXU) m_udw[a-8] = 10'(d);
    end
  endtask

  task automatic prog(input int n, input int did, input int sdid);
    wr(1, 10'h000, 1); wr(2, 10'h3FF, 1); wr(3, 10'h3FF, 1);
    wr(4, did, 1); wr(5, sdid, 1);
    wr(6, ((n % 2) != 0 ? 10'h100 : 10'h200) | n, 1);
    wr(7, 10'h155, 1);
    for (int k = 0; k < n && k < MAXU; k++) wr(8 + k, (k * 37 + n * 11 + 5) & 10'h3FF, 1);
  endtask

  task automatic run_line(input bit exp_ins, input bit bp, input bit midwr, input int seed);
    logic [9:0] sent [LINE];
    logic [9:0] got [LINE];
    logic [9:0] pk [32];
    logic [9:0] ev;
    logic [8:0] s;
    int ii, oc, cyc, n, len;
    bit d1, d2;
    ii = 0; oc = 0; cyc = 0; d1 = 0; d2 = 0;
    while (oc < LINE && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      in_valid  = (ii < LINE) && !(bp && (cyc % 5 == 2));
      in_data   = 10'((ii * 7 + 3 + seed) & 10'h3FF);
      win_start = (ii == WP);
      reg_we    = 1'b0;
      if (midwr && ii == WP + 2 && !d1) begin
        d1 = 1;
        chk(busy == 1'b1, "R8 busy during packet", int'(busy), 1);
        reg_we = 1'b1; reg_addr = AW'(8); reg_wdata = 10'h0AA;
      end else if (midwr && ii == WP + 3 && !d2) begin
        d2 = 1;
        reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 10'h003;
      end
      #1;
      if (out_valid && out_ready) begin got[oc] = out_data; oc++; end
      if (in_valid && in_ready) begin sent[ii] = in_data; ii++; end
    end
    @(negedge clk);
    in_valid = 1'b0; win_start = 1'b0; reg_we = 1'b0; out_ready = 1'b1;
    chk(oc == LINE, "R1 output count", oc, LINE);
    chk(busy == 1'b0, "R8 busy clear after line", int'(busy), 0);
    n = int'(m_dc[7:0]);
    len = n + 7;
    if (exp_ins) begin
      s = m_did[8:0] + m_sdid[8:0] + m_dc[8:0];
      for (int k = 0; k < n; k++) s = s + m_udw[k][8:0];
      pk[0] = m_adf[0]; pk[1] = m_adf[1]; pk[2] = m_adf[2];
      pk[3] = m_did; pk[4] = m_sdid; pk[5] = m_dc;
      for (int k = 0; k < n; k++) pk[6 + k] = m_udw[k];
      pk[6 + n] = {~s[8], s};
    end
    for (int i = 0; i < LINE; i++) begin
      if (exp_ins && i >= WP && i < WP + len) begin
        ev = pk[i - WP];
        if (i == WP + len - 1) chk(got[i] == ev, "R4 checksum word", int'(got[i]), int'(ev));
        else chk(got[i] == ev, "R3 packet word", int'(got[i]), int'(ev));
      end else begin
        chk(got[i] == sent[i], "R1 pass-through word", int'(got[i]), int'(sent[i]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smpte_mode = 1'b1; ins_en = 1'b1; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; in_valid = 1'b0; in_data = '0;
    win_start = 1'b0; win_len = '0; out_ready = 1'b1;
    for (int k = 0; k < MAXU; k++) m_udw[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);

    // table-driven scenarios (R2 map used by prog)
    for (int v = 0; v < NV; v++) begin
      smpte_mode = VEC[v][4][0];
      ins_en     = VEC[v][3][0];
      win_len    = LW'(VEC[v][1]);
      prog(VEC[v][0], 10'h041 + v, 10'h1C0 + v * 3);
      wr(0, {VEC[v][2][0], 1'b1} == 2'b11 ? 3 : 2, 1);
      run_line(VEC[v][6][0], VEC[v][5][0], 1'b0, v * 13);
    end
    smpte_mode = 1'b1; ins_en = 1'b1; win_len = LW'(20);

    // R5: no repeat without re-arming
    run_line(1'b0, 1'b0, 1'b0, 101);

    // R5: arm consumed by a disabled window
    ins_en = 1'b0;
    prog(2, 10'h2A5, 10'h07E);
    wr(0, 3, 1);
    run_line(1'b0, 1'b0, 1'b0, 202);
    ins_en = 1'b1;
    run_line(1'b0, 1'b0, 1'b0, 303);

    // R8: writes during a packet are ignored
    wr(0, 3, 1);
    run_line(1'b1, 1'b0, 1'b1, 404);
    run_line(1'b0, 1'b0, 1'b0, 505);
    wr(0, 3, 1);
    run_line(1'b1, 1'b0, 1'b0, 606);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule